// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the device side of the byte-wide host interface of a floppy disk controller. The host sees two locations: a status byte and a data port. A command is written one byte at a time into the data port. The low five bits of the first byte select the operation. The block then gathers that operation's parameter bytes, runs an execution phase where the command needs one, and offers result bytes for the host to read back. The status byte tells the host at every moment whether it may write a byte, read a byte, or must wait.

The supported operations are timing setup (0x03), controller configuration (0x13), version query (0x10), interrupt status query (0x08) and the framing of a sector read (0x06). Media access is not modelled: the read runs a fixed-length execution phase and reports success. The timing and configuration values are held on output ports so that neighbouring blocks can use them. Any other opcode is answered at once with an invalid-command status byte.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the status byte reads 0x80, and all timing, configuration and sector-size outputs are zero, except the sector size, which reads 128.
- R2: Status byte layout: bit 7 is ready-for-transfer (RQM), bit 6 is direction (1 = controller to host), bit 4 is busy (set from the first accepted command byte until the command has fully finished), and all other bits are 0.
- R3: After each accepted write to the data port, RQM stays 0 for exactly HOLD_CYC cycles.
- R4: A data-port write is accepted only while RQM=1 and direction=0. Any other write is ignored. Reading the status byte never changes state.
- R5: Opcode 0x03 takes two parameter bytes. Byte 1 gives the step rate in bits 7:4 and the head-unload time in bits 3:0. Byte 2 gives the head-load time in bits 7:1 and the non-DMA flag in bit 0. There is no result phase.
- R6: Opcode 0x13 takes three parameter bytes. Byte 1 is ignored. Byte 2 gives implied-seek in bit 6, FIFO-disable in bit 5, poll-disable in bit 4 and the FIFO threshold in bits 3:0. Byte 3 is the precompensation track. There is no result phase.
- R7: Opcode 0x10 takes no parameters and returns one result byte, 0x90.
- R8: Opcode 0x06, decoded from the low five bits only, takes eight parameter bytes: head/drive (head in bit 2, drive in bits 1:0), C, H, R, N, EOT, GPL and DTL. RQM then stays 0 for EXEC_CYC cycles. After that, seven result bytes are returned: ST0 = {00000, head, drive}, ST1 = 0, ST2 = 0, then C, H, R and N as written.
- R9: The sector-size output equals 128 shifted left by the N of the last read command when N is 7 or less, and 16384 when N is larger.
- R10: Opcode 0x08 returns two bytes: the ST0 and the cylinder of the last read command, both zero after reset.
- R11: Any other opcode takes no parameters and returns a single result byte, 0x80.
- R12: During the result phase the status shows RQM=1 and direction=1 until the last byte is read. It then shows 0x80 at once. A data-port read outside the result phase returns 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 selects the status byte, 1 selects the data port |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected location (combinational) |
| step_rate | output | 4 | Step rate code |
| head_unload | output | 4 | Head unload time code |
| head_load | output | 7 | Head load time code |
| non_dma | output | 1 | Non-DMA transfer flag |
| cfg_implied_seek | output | 1 | Implied seek enable |
| cfg_fifo_dis | output | 1 | FIFO disable |
| cfg_poll_dis | output | 1 | Drive polling disable |
| cfg_fifo_thr | output | 4 | FIFO threshold |
| cfg_precomp_trk | output | 8 | Precompensation start track |
| sector_bytes | output | 15 | Sector size of the last read command, in bytes |

## Verification
The hardest situation to reach from the ports is a write that arrives while RQM is low. A host that follows the protocol never produces one. The bench therefore adds a raw write path that skips the status poll. It fires a byte in the cycle right after an accepted command byte, and another one in the middle of a result phase. Then it checks that the stored timing value comes only from the bytes sent later, and that the result stream is unchanged. The execution window is measured cycle by cycle by counting low-RQM samples after the last read parameter.

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq #(
  parameter int HOLD_CYC = 3,
  parameter int EXEC_CYC = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic [3:0]  step_rate,
  output logic [3:0]  head_unload,
  output logic [6:0]  head_load,
  output logic        non_dma,
  output logic        cfg_implied_seek,
  output logic        cfg_fifo_dis,
  output logic        cfg_poll_dis,
  output logic [3:0]  cfg_fifo_thr,
  output logic [7:0]  cfg_precomp_trk,
  output logic [14:0] sector_bytes
);
  localparam int MAXC = (HOLD_CYC > EXEC_CYC) ? HOLD_CYC : EXEC_CYC;
  localparam int CW   = $clog2(MAXC + 1) + 1;
  localparam logic [4:0] OP_SPEC = 5'h03, OP_SENSE = 5'h08, OP_READ = 5'h06,
                         OP_VER  = 5'h10, OP_CONF  = 5'h13;

  typedef enum logic [1:0] {S_IDLE, S_PARAM, S_EXEC, S_RESULT} phase_t;

  phase_t      phase;
  logic [CW-1:0] cnt;
  logic [4:0]  opc;
  logic [3:0]  pidx;
  logic [7:0]  pb  [0:7];
  logic [7:0]  res [0:6];
  logic [2:0]  ridx, rlast;
  logic [7:0]  last_st0, last_cyl, nsize;

  logic rqm, dio, busy, wr_ok, rd_ok;
  assign rqm   = (cnt == '0) && (phase != S_EXEC);
  assign dio   = (phase == S_RESULT);
  assign busy  = (phase != S_IDLE);
  assign wr_ok = host_wr && host_sel && rqm && !dio;
  assign rd_ok = host_rd && host_sel && rqm && dio;

  assign host_rdata   = !host_sel ? {rqm, dio, 1'b0, busy, 4'b0000}
                      : (rqm && dio) ? res[ridx] : 8'h00;
  assign sector_bytes = (nsize > 8'd7) ? 15'd16384 : (15'd128 << nsize[2:0]);

  function automatic logic [3:0] nparams(input logic [4:0] op);
    case (op)
      OP_SPEC: nparams = 4'd2;
      OP_CONF: nparams = 4'd3;
      OP_READ: nparams = 4'd8;
      default: nparams = 4'd0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= S_IDLE; cnt <= '0; opc <= '0; pidx <= '0; ridx <= '0; rlast <= '0;
      last_st0 <= '0; last_cyl <= '0; nsize <= '0;
      step_rate <= '0; head_unload <= '0; head_load <= '0; non_dma <= 1'b0;
      cfg_implied_seek <= 1'b0; cfg_fifo_dis <= 1'b0; cfg_poll_dis <= 1'b0;
      cfg_fifo_thr <= '0; cfg_precomp_trk <= '0;
      for (int i = 0; i < 8; i++) pb[i] <= '0;
      for (int i = 0; i < 7; i++) res[i] <= '0;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (phase)
        S_IDLE: if (wr_ok) begin
          opc  <= host_wdata[4:0];
          pidx <= '0;
          ridx <= '0;
          cnt  <= CW'(HOLD_CYC);
          case (host_wdata[4:0])
            OP_SPEC, OP_CONF, OP_READ: phase <= S_PARAM;
            OP_VER:   begin res[0] <= 8'h90; rlast <= 3'd0; phase <= S_RESULT; end
            OP_SENSE: begin res[0] <= last_st0; res[1] <= last_cyl; rlast <= 3'd1; phase <= S_RESULT; end
            default:  begin res[0] <= 8'h80; rlast <= 3'd0; phase <= S_RESULT; end
          endcase
        end
        S_PARAM: if (wr_ok) begin
          pb[pidx[2:0]] <= host_wdata;
          pidx <= pidx + 1'b1;
          cnt  <= CW'(HOLD_CYC);
          if (pidx == nparams(opc) - 1'b1) begin
            phase <= S_IDLE;
            case (opc)
              OP_SPEC: begin
                step_rate <= pb[0][7:4]; head_unload <= pb[0][3:0];
                head_load <= host_wdata[7:1]; non_dma <= host_wdata[0];
              end
              OP_CONF: begin
                cfg_implied_seek <= pb[1][6]; cfg_fifo_dis <= pb[1][5];
                cfg_poll_dis <= pb[1][4]; cfg_fifo_thr <= pb[1][3:0];
                cfg_precomp_trk <= host_wdata;
              end
              default: begin
                res[0] <= {5'b00000, pb[0][2:0]};
                res[1] <= 8'h00; res[2] <= 8'h00;
                res[3] <= pb[1]; res[4] <= pb[2]; res[5] <= pb[3]; res[6] <= pb[4];
                last_st0 <= {5'b00000, pb[0][2:0]};
                last_cyl <= pb[1];
                nsize <= pb[4];
                rlast <= 3'd6;
                cnt   <= CW'(EXEC_CYC - 1);
                phase <= S_EXEC;
              end
            endcase
          end
        end
        S_EXEC: if (cnt == '0) phase <= S_RESULT;
        S_RESULT: if (rd_ok) begin
          if (ridx == rlast) phase <= S_IDLE;
          else ridx <= ridx + 1'b1;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  p_hold_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (HOLD_CYC > 0 && wr_ok) |=> !rqm);

  p_result_end_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dio) |-> (rqm && !busy));

  p_timing_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> ($stable(step_rate) && $stable(head_load) && $stable(cfg_fifo_thr)));

  p_invalid_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_IDLE && wr_ok && nparams(host_wdata[4:0]) == 4'd0 &&
     host_wdata[4:0] != OP_VER && host_wdata[4:0] != OP_SENSE)
    |=> (dio && res[0] == 8'h80 && rlast == 3'd0));

  p_read_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !dio && phase != S_EXEC) |=> $stable(ridx));
endmodule

// File: tb/fdc_cmd_seq_test.sv
module fdc_cmd_seq_test;
  localparam int HOLD = 3;
  localparam int EXEC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [3:0] step_rate, head_unload, cfg_fifo_thr;
  logic [6:0] head_load;
  logic non_dma, cfg_implied_seek, cfg_fifo_dis, cfg_poll_dis;
  logic [7:0] cfg_precomp_trk;
  logic [14:0] sector_bytes;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fdc_cmd_seq #(.HOLD_CYC(HOLD), .EXEC_CYC(EXEC)) uut (
    .clk, .rst_n, .host_sel, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .step_rate, .head_unload, .head_load, .non_dma, .cfg_implied_seek,
    .cfg_fifo_dis, .cfg_poll_dis, .cfg_fifo_thr, .cfg_precomp_trk, .sector_bytes);

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic status(output logic [7:0] s);
    host_sel = 1'b0; #1; s = host_rdata;
  endtask

  task automatic host_write(input logic [7:0] b);
    logic [7:0] s;
    forever begin
      @(negedge clk); status(s);
      if (s[7:6] == 2'b10) break;
    end
    host_sel = 1'b1; host_wr = 1'b1; host_wdata = b;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic raw_write(input logic [7:0] b);
    host_sel = 1'b1; host_wr = 1'b1; host_wdata = b;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] b);
    logic [7:0] s;
    forever begin
      @(negedge clk); status(s);
      if (s[7:6] == 2'b11) break;
    end
    host_sel = 1'b1; host_rd = 1'b1; #1; b = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic count_low(output int n);
    logic [7:0] s;
    n = 0;
    forever begin
      status(s);
      if (s[7]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] s;
    @(negedge clk); status(s);
    chk("R1 status", s, 8'h80);
    chk("R1 config", {step_rate, head_unload, head_load, non_dma, cfg_fifo_thr, cfg_precomp_trk}, 0);
    chk("R1 sector", sector_bytes, 128);
  endtask

  task automatic t_specify;
    logic [7:0] s;
    host_write(8'h03);
    status(s);
    chk("R2 busy during hold", s, 8'h10);
    raw_write(8'h55);
    host_write(8'hD7);
    host_write(8'h05);
    chk("R4 ignored write / R5 step", step_rate, 4'hD);
    chk("R5 unload", head_unload, 4'h7);
    chk("R5 load", head_load, 7'h02);
    chk("R5 non-dma", non_dma, 1);
    @(negedge clk); @(negedge clk); @(negedge clk); status(s);
    chk("R5 idle after", s, 8'h80);
  endtask

  task automatic t_hold;
    int n;
    host_write(8'h03);
    count_low(n);
    chk("R3 hold length", n, HOLD);
    host_write(8'hD7);
    host_write(8'h05);
  endtask

  task automatic t_configure;
    host_write(8'h13);
    host_write(8'hAA);
    host_write(8'h5A);
    host_write(8'h2C);
    chk("R6 implied seek", cfg_implied_seek, 1);
    chk("R6 fifo dis", cfg_fifo_dis, 0);
    chk("R6 poll dis", cfg_poll_dis, 1);
    chk("R6 thr", cfg_fifo_thr, 4'hA);
    chk("R6 precomp", cfg_precomp_trk, 8'h2C);
  endtask

  task automatic t_version;
    logic [7:0] b, s;
    host_write(8'h10);
    @(negedge clk); @(negedge clk); @(negedge clk); status(s);
    chk("R12 result status", s, 8'hD0);
    raw_write(8'h03);
    host_read(b);
    chk("R7 version", b, 8'h90);
    status(s);
    chk("R12 idle after last byte / R4", s, 8'h80);
  endtask

  task automatic t_sense(input logic [7:0] e0, input logic [7:0] e1);
    logic [7:0] b;
    host_write(8'h08);
    host_read(b); chk("R10 st0", b, e0);
    host_read(b); chk("R10 cyl", b, e1);
  endtask

  task automatic t_read(input logic [7:0] nval, input int ebytes);
    logic [7:0] p [0:7];
    logic [7:0] e [0:6];
    logic [7:0] b;
    int n;
    p = '{8'h05, 8'h21, 8'h01, 8'h03, nval, 8'h12, 8'h1B, 8'hFF};
    e = '{8'h05, 8'h00, 8'h00, 8'h21, 8'h01, 8'h03, nval};
    host_write(8'h46);
    for (int i = 0; i < 8; i++) host_write(p[i]);
    count_low(n);
    chk("R8 exec length", n, EXEC);
    for (int i = 0; i < 7; i++) begin
      host_read(b); chk("R8 result byte", b, e[i]);
    end
    chk("R9 sector bytes", sector_bytes, ebytes);
  endtask

  task automatic t_invalid;
    logic [7:0] b, s;
    host_write(8'h1F);
    host_read(b);
    chk("R11 invalid", b, 8'h80);
    status(s);
    chk("R11 idle", s, 8'h80);
  endtask

  task automatic t_idle_read;
    logic [7:0] s;
    @(negedge clk);
    host_sel = 1'b1; host_rd = 1'b1; #1;
    chk("R12 idle data read", host_rdata, 0);
    @(negedge clk); host_rd = 1'b0;
    status(s);
    chk("R12 idle unchanged", s, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_sense(8'h00, 8'h00);
    t_specify;
    t_hold;
    t_configure;
    t_version;
    t_read(8'h02, 512);
    t_sense(8'h05, 8'h21);
    t_read(8'h09, 16384);
    t_invalid;
    t_idle_read;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule